// File: doc/BRIEF.md
# 100BASE-X Receive Symbol Decoder

This block sits in a 100 Mb/s receive path after descrambling. It takes one code-group bit per clock and produces nibble-wide receive signals for a MAC: carrier sense, a data-valid strobe, an error flag and a 4-bit data nibble. Bits arrive with the leftmost bit of each 5-bit code group first.

While the line is idle, the block watches a sliding 10-bit window for carrier. When carrier appears, it checks whether the disturbance is a start-of-stream J symbol. If so, it locks code-group alignment at that bit position. It then expects K and decodes every following 5-bit group through the 4B/5B table until the frame ends.

A frame ends on one of two conditions: an end-of-stream T followed by one more group, or two back-to-back idle groups. A disturbance that does not start with J and K is reported as a false carrier. The false-carrier report holds until a clean run of idle bits is seen. Outputs change only at code-group boundaries once a frame has started.

Top module: `sym100_rx_decode`

## Requirements
- R1: While the active-low reset is asserted, crs, rx_dv, rx_er and rxd are all 0.
- R2: An all-ones stream, a lone zero bit, or two adjacent zero bits leave all outputs at 0.
- R3: crs rises on the clock edge that samples the bit completing two non-adjacent zero bits within the last 10 bits, and not before.
- R4: Carrier whose last five bits are J (11000, leftmost bit first) sets rx_dv=1 and rxd=0101 on that edge. A following K (10001) keeps rx_dv=1 and rxd=0101 for one more group.
- R5: Inside a frame, each data code group is decoded with 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101. The result appears on rxd with rx_dv=1 and rx_er=0 at the edge that samples the group's fifth bit. Outputs hold between group boundaries.
- R6: A T group (01101) drops rx_dv and sets rxd=0 while crs stays 1. The next group (R, 00111) drops crs and returns the block to idle.
- R7: An in-frame group that is neither data, T nor idle sets rx_er=1 with rx_dv=1 and rxd=0 for that nibble only. The next valid data group clears rx_er.
- R8: A single idle group (11111) inside a frame sets rx_er=1 with rx_dv=1 and rxd=0. A second consecutive idle group drops crs, rx_dv and rx_er to 0.
- R9: Carrier that does not start with J, or a J not followed by K, gives a false carrier indication: crs=1, rx_dv=0, rx_er=1, rxd=1110.
- R10: The false carrier indication holds until ten consecutive one bits have been sampled. On that edge all outputs return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one code bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Descrambled code-group bit, leftmost bit first |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error, or false carrier when rx_dv is 0 |
| rxd | output | 4 | Receive nibble |

## Verification
A wrong alignment point or a wrong bit counter shows up within one code group. It appears as a wrong nibble right after the K preamble, or as outputs that change at a bit which is not a group boundary. A carrier window that is off by one bit moves the rise of crs by one clock relative to the J symbol, so the bench samples crs both one bit before and exactly at the completing bit. Wrong end-of-frame handling leaves crs or rx_dv high one group too long, after T, after R, or after the second idle group. Each of these is checked at the group edge where the change is due.

// File: rtl/sym100_rx_decode.sv
module sym100_rx_decode #(
  parameter int WIN = 10,
  parameter int GW  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  output logic       crs,
  output logic       rx_dv,
  output logic       rx_er,
  output logic [3:0] rxd
);
  localparam int CW = $clog2(GW);
  localparam logic [CW-1:0] LAST = CW'(GW - 1);
  localparam logic [4:0] SYM_J = 5'b11000;
  localparam logic [4:0] SYM_K = 5'b10001;
  localparam logic [4:0] SYM_T = 5'b01101;
  localparam logic [4:0] SYM_I = 5'b11111;
  localparam logic [3:0] NIB_PRE = 4'h5;
  localparam logic [3:0] NIB_FC  = 4'hE;

  typedef enum logic [2:0] {S_IDLE, S_K, S_DATA, S_TAIL, S_FALSE} st_t;

  st_t           st;
  logic [WIN-1:0] sh;
  logic [WIN-1:0] win;
  logic [CW-1:0] cnt;
  logic          idle1;
  logic          zpair;
  logic [4:0]    dec;
  logic [4:0]    grp;

  assign win = {sh[WIN-2:0], rx_bit};
  assign grp = win[4:0];

  always_comb begin
    zpair = 1'b0;
    for (int i = 0; i < WIN - 2; i++)
      for (int j = i + 2; j < WIN; j++)
        if (!win[i] && !win[j]) zpair = 1'b1;
  end

  always_comb begin
    case (grp)
      5'b11110: dec = 5'h10;
      5'b01001: dec = 5'h11;
      5'b10100: dec = 5'h12;
      5'b10101: dec = 5'h13;
      5'b01010: dec = 5'h14;
      5'b01011: dec = 5'h15;
      5'b01110: dec = 5'h16;
      5'b01111: dec = 5'h17;
      5'b10010: dec = 5'h18;
      5'b10011: dec = 5'h19;
      5'b10110: dec = 5'h1A;
      5'b10111: dec = 5'h1B;
      5'b11010: dec = 5'h1C;
      5'b11011: dec = 5'h1D;
      5'b11100: dec = 5'h1E;
      5'b11101: dec = 5'h1F;
      default:  dec = 5'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sh    <= '1;
      cnt   <= '0;
      idle1 <= 1'b0;
      crs   <= 1'b0;
      rx_dv <= 1'b0;
      rx_er <= 1'b0;
      rxd   <= '0;
    end else begin
      sh <= win;
      case (st)
        S_IDLE: begin
          if (zpair) begin
            crs <= 1'b1;
            cnt <= '0;
            if (grp == SYM_J) begin
              st    <= S_K;
              rx_dv <= 1'b1;
              rxd   <= NIB_PRE;
            end else begin
              st    <= S_FALSE;
              rx_er <= 1'b1;
              rxd   <= NIB_FC;
            end
          end
        end
        S_FALSE: begin
          if (&win) begin
            st    <= S_IDLE;
            crs   <= 1'b0;
            rx_er <= 1'b0;
            rxd   <= '0;
          end
        end
        default: begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (cnt == LAST) begin
            case (st)
              S_K: begin
                if (grp == SYM_K) begin
                  st    <= S_DATA;
                  rxd   <= NIB_PRE;
                  idle1 <= 1'b0;
                end else begin
                  st    <= S_FALSE;
                  rx_dv <= 1'b0;
                  rx_er <= 1'b1;
                  rxd   <= NIB_FC;
                end
              end
              S_DATA: begin
                if (grp == SYM_T) begin
                  st    <= S_TAIL;
                  rx_dv <= 1'b0;
                  rx_er <= 1'b0;
                  rxd   <= '0;
                end else if (grp == SYM_I) begin
                  idle1 <= 1'b1;
                  rxd   <= '0;
                  if (idle1) begin
                    st    <= S_IDLE;
                    crs   <= 1'b0;
                    rx_dv <= 1'b0;
                    rx_er <= 1'b0;
                    sh    <= '1;
                  end else begin
                    rx_er <= 1'b1;
                  end
                end else begin
                  idle1 <= 1'b0;
                  rx_er <= ~dec[4];
                  rxd   <= dec[3:0];
                end
              end
              default: begin
                st    <= S_IDLE;
                crs   <= 1'b0;
                rx_dv <= 1'b0;
                rx_er <= 1'b0;
                rxd   <= '0;
                sh    <= '1;
              end
            endcase
          end
        end
      endcase
    end
  end

  a_r4_dv_under_crs: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv |-> crs);

  a_r4_dv_starts_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> rxd == NIB_PRE);

  a_r5_hold_between_groups: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable({crs, rx_dv, rx_er, rxd}));

  a_r9_false_carrier_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && !rx_dv) |-> (crs && rxd == NIB_FC));

  a_r6_crs_drop_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs) |-> (!rx_dv && !rx_er && rxd == 4'h0));
endmodule

// File: tb/sym100_rx_decode_test.sv
`timescale 1ns/100ps
module sym100_rx_decode_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b1;
  logic       crs, rx_dv, rx_er;
  logic [3:0] rxd;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sym100_rx_decode uut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
    .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd)
  );

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  task automatic chk(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {crs, rx_dv, rx_er, rxd};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s {crs,dv,er,rxd} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b;
    @(posedge clk);
    #1;
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic start_frame();
    send_grp(5'b11000);
    send_grp(5'b10001);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    rx_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 7'b000_0000);
    rx_bit = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic t_quiet();
    send_ones(20);
    chk("R2", 7'b000_0000);
    send_bit(1'b0);
    send_ones(10);
    chk("R2", 7'b000_0000);
    send_bit(1'b0);
    send_bit(1'b0);
    send_ones(10);
    chk("R2", 7'b000_0000);
  endtask

  task automatic t_false_carrier();
    send_ones(10);
    send_bit(1'b0);
    send_bit(1'b1);
    chk("R3", 7'b000_0000);
    send_bit(1'b0);
    chk("R9", {3'b101, 4'hE});
    send_ones(9);
    chk("R10", {3'b101, 4'hE});
    send_bit(1'b1);
    chk("R10", 7'b000_0000);
  endtask

  task automatic t_frame();
    send_ones(10);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    chk("R3", 7'b000_0000);
    send_bit(1'b0);
    chk("R4", {3'b110, 4'h5});
    send_grp(5'b10001);
    chk("R4", {3'b110, 4'h5});
    for (int n = 0; n < 16; n++) begin
      logic [4:0] c;
      c = enc(4'(n));
      if (n == 9) begin
        send_bit(c[4]); send_bit(c[3]); send_bit(c[2]);
        chk("R5", {3'b110, 4'h8});
        send_bit(c[1]); send_bit(c[0]);
      end else begin
        send_grp(c);
      end
      chk("R5", {3'b110, 4'(n)});
    end
    send_grp(5'b01101);
    chk("R6", 7'b100_0000);
    send_grp(5'b00111);
    chk("R6", 7'b000_0000);
    send_ones(10);
    chk("R6", 7'b000_0000);
  endtask

  task automatic t_errors();
    send_ones(10);
    start_frame();
    send_grp(enc(4'h3));
    send_grp(5'b00100);
    chk("R7", {3'b111, 4'h0});
    send_grp(enc(4'hA));
    chk("R7", {3'b110, 4'hA});
    send_grp(5'b11111);
    chk("R8", {3'b111, 4'h0});
    send_grp(enc(4'h7));
    chk("R8", {3'b110, 4'h7});
    send_grp(5'b11111);
    chk("R8", {3'b111, 4'h0});
    send_grp(5'b11111);
    chk("R8", 7'b000_0000);
    send_ones(10);
    chk("R8", 7'b000_0000);
  endtask

  task automatic t_k_missing();
    send_ones(10);
    send_grp(5'b11000);
    send_grp(enc(4'h0));
    chk("R9", {3'b101, 4'hE});
    send_grp(5'b11111);
    chk("R10", {3'b101, 4'hE});
    send_grp(5'b11111);
    chk("R10", 7'b000_0000);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_quiet();
    t_false_carrier();
    t_frame();
    t_errors();
    t_k_missing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule